// File: doc/BRIEF.md
# Endpoint Double-Buffer Manager

This block keeps the buffer descriptors of every endpoint of a USB device controller. Each endpoint has two descriptor words that point into a shared packet memory. When the protocol engine presents a token, the block answers in the same cycle with the start address of the buffer to use, or with a refusal (NAK). When the engine reports that a transfer finished, the block marks that buffer as used. On a bulk-style endpoint it then moves to the other buffer without any software action.

A control endpoint works differently. Its OUT data always goes to buffer 0 and its IN data always comes from buffer 1. There is one buffer in each direction. The start of a setup packet releases both of its buffers. Software sets up types, interrupt masks and descriptors over a 32-bit word-addressed register port and clears interrupt flags there. Each endpoint drives one interrupt line. The packet memory is not part of this block: it only supplies the address that the engine uses to reach it.

Top module: `ep_dbuf_mgr`

## Requirements
- R1: After reset every register of every endpoint reads as zero (type control, mask off, pointer at buffer 0, descriptors zero, used bits clear), and `ep_irq` is all zero.
- R2: On an IN (type 01) or OUT (type 10) endpoint, the first accepted token after reset is granted buffer 0. Each accepted completion then moves the pointer to the buffer other than the one just filled, so successive transfers alternate 0, 1, 0, … with no register access in between.
- R3: An accepted completion sets the used flag, bit 31 of the descriptor word, of exactly the buffer that the matching token was granted.
- R4: On an IN or OUT endpoint whose two used flags are both set, a token gets `grant_nak`=1 and a completion is ignored. When only one buffer is free, that buffer is granted whatever the pointer says.
- R5: The endpoint type field encodes 00 control, 01 IN, 10 OUT, 11 reserved, and `tok_in`=1 marks an IN token. An OUT token on an IN endpoint, an IN token on an OUT endpoint, and any token on a reserved endpoint get `grant_nak`=1, and a completion of that kind changes nothing.
- R6: On a control endpoint an OUT token is granted buffer 0 and an IN token buffer 1. The token is refused while that buffer's used flag is set, and a completion sets the flag of that same buffer.
- R7: `setup_start` on a control endpoint clears both of its used flags. On any other endpoint type it has no effect.
- R8: A write to a descriptor word stores write-data bits 30:0 (bits ADDR_W-1:0 become the grant address) and clears that buffer's used flag.
- R9: An accepted completion sets the endpoint's interrupt flag, seen on `ep_irq[ep]` in the next cycle, only if the mask bit is 1. With the mask at 0 the flag is not set.
- R10: Register word address = endpoint*4 + word. Word 0 is the configuration word: bits 1:0 type, bit 2 interrupt mask, bit 4 current pointer (read-only). Word 1 holds the interrupt flag in bit 0. Word 2 is descriptor 0 and word 3 is descriptor 1, each with the used flag in bit 31.
- R11: Writing the configuration word with bit 31 = 1 returns the pointer to buffer 0. If a completion is accepted in the same cycle, the completion takes precedence.
- R12: Writing word 1 with bit 0 = 1 clears the interrupt flag. A completion that sets the flag in the same cycle takes precedence over the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | $clog2(NUM_EP)+2 | Register word address (endpoint, word) |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| tok_valid | input | 1 | Token lookup request |
| tok_ep | input | $clog2(NUM_EP) | Endpoint of the token |
| tok_in | input | 1 | 1 for an IN token, 0 for OUT |
| grant_addr | output | ADDR_W | Start address of the granted buffer |
| grant_buf | output | 1 | Index of the granted buffer |
| grant_nak | output | 1 | Token refused |
| done_valid | input | 1 | Transfer-complete event |
| done_ep | input | $clog2(NUM_EP) | Endpoint of the completed transfer |
| done_in | input | 1 | Direction of the completed transfer |
| setup_start | input | 1 | Setup packet reception begins |
| setup_ep | input | $clog2(NUM_EP) | Endpoint receiving the setup packet |
| ep_irq | output | NUM_EP | Per-endpoint interrupt flags |

## Verification
Some properties are checked on every cycle. A granted buffer never has its used flag set. A control endpoint always grants the buffer that matches the token direction. After a completion on an IN or OUT endpoint, the pointer sits opposite a buffer that is now used. A setup start leaves a control endpoint with both flags clear. An interrupt flag rises only after a masked-in completion. Other behaviour shows only in the bench scenarios: the exact alternation order, completions ignored once both buffers are used, the pointer restart, descriptor contents and the register layout. The bench tracks each of these in its own model of every endpoint.

// File: rtl/ep_dbuf_pkg.sv
`timescale 1ns/1ps
package ep_dbuf_pkg;

  typedef enum logic [1:0] {
    KIND_CTRL = 2'b00,
    KIND_IN   = 2'b01,
    KIND_OUT  = 2'b10,
    KIND_RSVD = 2'b11
  } ep_kind_e;

  // descriptor word bits kept by a buffer register (bit 31 is the used flag)
  localparam int DESC_W = 31;

  // register word index inside one endpoint's four-word group
  localparam logic [1:0] W_CFG  = 2'd0;
  localparam logic [1:0] W_IRQ  = 2'd1;
  localparam logic [1:0] W_BUF0 = 2'd2;
  localparam logic [1:0] W_BUF1 = 2'd3;

  // buffer that a transfer of direction tin would use
  function automatic logic pick_buf(ep_kind_e k, logic tin, logic act,
                                    logic u0, logic u1);
    if (k == KIND_CTRL) return tin;
    if (act ? u1 : u0) return ~act;
    return act;
  endfunction

  // 1 when the endpoint must refuse a transfer of direction tin
  function automatic logic refuse(ep_kind_e k, logic tin, logic u0, logic u1);
    case (k)
      KIND_CTRL: return tin ? u1 : u0;
      KIND_IN:   return !tin || (u0 && u1);
      KIND_OUT:  return tin || (u0 && u1);
      default:   return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/ep_dbuf_slot.sv
`timescale 1ns/1ps
module ep_dbuf_slot
  import ep_dbuf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_bits,
  input  logic              cfg_restart,
  input  logic              irq_we,
  input  logic              irq_clr_bit,
  input  logic [1:0]        buf_we,
  input  logic [DESC_W-1:0] desc_wdata,
  input  logic              done_hit,
  input  logic              done_in,
  input  logic              setup_hit,
  output logic [1:0]        kind_o,
  output logic              mask_o,
  output logic              act_o,
  output logic [1:0]        used_o,
  output logic [DESC_W-1:0] desc0_o,
  output logic [DESC_W-1:0] desc1_o,
  output logic              irq_o,
  output logic              done_take_o
);

  ep_kind_e          kind_q;
  logic              mask_q, act_q, irq_q;
  logic              act_d, irq_d, take_buf;
  logic [1:0]        used_q, used_d;
  logic [DESC_W-1:0] desc_q [2];

  assign done_take_o = done_hit && !refuse(kind_q, done_in, used_q[0], used_q[1]);
  assign take_buf    = pick_buf(kind_q, done_in, act_q, used_q[0], used_q[1]);

  always_comb begin
    used_d = used_q;
    for (int b = 0; b < 2; b++)
      if (buf_we[b]) used_d[b] = 1'b0;
    if (done_take_o) used_d[take_buf] = 1'b1;
    if (setup_hit && kind_q == KIND_CTRL) used_d = 2'b00;
  end

  always_comb begin
    act_d = act_q;
    if (cfg_we && cfg_restart) act_d = 1'b0;
    if (done_take_o && kind_q != KIND_CTRL) act_d = ~take_buf;
  end

  always_comb begin
    irq_d = irq_q;
    if (irq_we && irq_clr_bit) irq_d = 1'b0;
    if (done_take_o && mask_q) irq_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind_q <= KIND_CTRL;
      mask_q <= 1'b0;
      act_q  <= 1'b0;
      irq_q  <= 1'b0;
      used_q <= 2'b00;
    end else begin
      if (cfg_we) begin
        kind_q <= ep_kind_e'(cfg_bits[1:0]);
        mask_q <= cfg_bits[2];
      end
      act_q  <= act_d;
      irq_q  <= irq_d;
      used_q <= used_d;
    end
  end

  for (genvar b = 0; b < 2; b++) begin : g_desc
    always_ff @(posedge clk) begin
      if (!rst_n)         desc_q[b] <= '0;
      else if (buf_we[b]) desc_q[b] <= desc_wdata;
    end
  end

  assign kind_o  = kind_q;
  assign mask_o  = mask_q;
  assign act_o   = act_q;
  assign used_o  = used_q;
  assign desc0_o = desc_q[0];
  assign desc1_o = desc_q[1];
  assign irq_o   = irq_q;

endmodule

// File: rtl/ep_dbuf_lookup.sv
`timescale 1ns/1ps
module ep_dbuf_lookup
  import ep_dbuf_pkg::*;
#(
  parameter int NUM_EP = 4,
  parameter int ADDR_W = 12
) (
  input  logic                              tok_valid,
  input  logic                              tok_in,
  input  logic [$clog2(NUM_EP)-1:0]         tok_ep,
  input  logic [NUM_EP-1:0][1:0]            kind_v,
  input  logic [NUM_EP-1:0]                 act_v,
  input  logic [NUM_EP-1:0]                 used0_v,
  input  logic [NUM_EP-1:0]                 used1_v,
  input  logic [NUM_EP-1:0][ADDR_W-1:0]     addr0_v,
  input  logic [NUM_EP-1:0][ADDR_W-1:0]     addr1_v,
  output logic [ADDR_W-1:0]                 grant_addr,
  output logic                              grant_buf,
  output logic                              grant_nak
);

  ep_kind_e k;
  logic     sel;

  always_comb begin
    k          = ep_kind_e'(kind_v[tok_ep]);
    sel        = pick_buf(k, tok_in, act_v[tok_ep], used0_v[tok_ep], used1_v[tok_ep]);
    grant_buf  = sel;
    grant_addr = sel ? addr1_v[tok_ep] : addr0_v[tok_ep];
    grant_nak  = tok_valid && refuse(k, tok_in, used0_v[tok_ep], used1_v[tok_ep]);
  end

endmodule

// File: rtl/ep_dbuf_mgr.sv
`timescale 1ns/1ps
module ep_dbuf_mgr
  import ep_dbuf_pkg::*;
#(
  parameter int NUM_EP = 4,
  parameter int ADDR_W = 12
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [$clog2(NUM_EP)+1:0]   reg_addr,
  input  logic                        reg_we,
  input  logic [31:0]                 reg_wdata,
  output logic [31:0]                 reg_rdata,
  input  logic                        tok_valid,
  input  logic [$clog2(NUM_EP)-1:0]   tok_ep,
  input  logic                        tok_in,
  output logic [ADDR_W-1:0]           grant_addr,
  output logic                        grant_buf,
  output logic                        grant_nak,
  input  logic                        done_valid,
  input  logic [$clog2(NUM_EP)-1:0]   done_ep,
  input  logic                        done_in,
  input  logic                        setup_start,
  input  logic [$clog2(NUM_EP)-1:0]   setup_ep,
  output logic [NUM_EP-1:0]           ep_irq
);

  localparam int EPW = $clog2(NUM_EP);
  localparam int RAW = EPW + 2;

  logic [EPW-1:0]                  sel_ep;
  logic [1:0]                      sel_word;
  logic [NUM_EP-1:0][1:0]          kind_v;
  logic [NUM_EP-1:0]               mask_v, act_v, used0_v, used1_v, done_take_v;
  logic [NUM_EP-1:0][1:0]          used_v;
  logic [NUM_EP-1:0][DESC_W-1:0]   desc0_v, desc1_v;
  logic [NUM_EP-1:0][ADDR_W-1:0]   addr0_v, addr1_v;

  assign sel_ep   = reg_addr[RAW-1:2];
  assign sel_word = reg_addr[1:0];

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    localparam logic [EPW-1:0] IDX = EPW'(i);
    logic hit;
    assign hit = reg_we && (sel_ep == IDX);

    ep_dbuf_slot u_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_we      (hit && sel_word == W_CFG),
      .cfg_bits    (reg_wdata[2:0]),
      .cfg_restart (reg_wdata[31]),
      .irq_we      (hit && sel_word == W_IRQ),
      .irq_clr_bit (reg_wdata[0]),
      .buf_we      ({hit && sel_word == W_BUF1, hit && sel_word == W_BUF0}),
      .desc_wdata  (reg_wdata[DESC_W-1:0]),
      .done_hit    (done_valid && done_ep == IDX),
      .done_in     (done_in),
      .setup_hit   (setup_start && setup_ep == IDX),
      .kind_o      (kind_v[i]),
      .mask_o      (mask_v[i]),
      .act_o       (act_v[i]),
      .used_o      (used_v[i]),
      .desc0_o     (desc0_v[i]),
      .desc1_o     (desc1_v[i]),
      .irq_o       (ep_irq[i]),
      .done_take_o (done_take_v[i])
    );

    assign used0_v[i] = used_v[i][0];
    assign used1_v[i] = used_v[i][1];
    assign addr0_v[i] = desc0_v[i][ADDR_W-1:0];
    assign addr1_v[i] = desc1_v[i][ADDR_W-1:0];
  end

  ep_dbuf_lookup #(.NUM_EP(NUM_EP), .ADDR_W(ADDR_W)) u_lookup (
    .tok_valid  (tok_valid),
    .tok_in     (tok_in),
    .tok_ep     (tok_ep),
    .kind_v     (kind_v),
    .act_v      (act_v),
    .used0_v    (used0_v),
    .used1_v    (used1_v),
    .addr0_v    (addr0_v),
    .addr1_v    (addr1_v),
    .grant_addr (grant_addr),
    .grant_buf  (grant_buf),
    .grant_nak  (grant_nak)
  );

  always_comb begin
    case (sel_word)
      W_CFG:   reg_rdata = {27'b0, act_v[sel_ep], 1'b0, mask_v[sel_ep], kind_v[sel_ep]};
      W_IRQ:   reg_rdata = {31'b0, ep_irq[sel_ep]};
      W_BUF0:  reg_rdata = {used0_v[sel_ep], desc0_v[sel_ep]};
      default: reg_rdata = {used1_v[sel_ep], desc1_v[sel_ep]};
    endcase
  end

endmodule

// File: rtl/ep_dbuf_mgr_chk.sv
`timescale 1ns/1ps
module ep_dbuf_mgr_chk #(
  parameter int NUM_EP = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      tok_valid,
  input logic                      tok_in,
  input logic [$clog2(NUM_EP)-1:0] tok_ep,
  input logic                      grant_buf,
  input logic                      grant_nak,
  input logic                      setup_start,
  input logic [$clog2(NUM_EP)-1:0] setup_ep,
  input logic [NUM_EP-1:0][1:0]    kind_v,
  input logic [NUM_EP-1:0]         act_v,
  input logic [NUM_EP-1:0][1:0]    used_v,
  input logic [NUM_EP-1:0]         done_take_v,
  input logic [NUM_EP-1:0]         mask_v,
  input logic [NUM_EP-1:0]         ep_irq
);

  // R4: a granted buffer is never one that is still marked used
  p_no_used_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && !grant_nak) |-> !used_v[tok_ep][grant_buf]);

  // R6: control endpoints grant the buffer fixed by direction
  p_ctrl_fixed_buf_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && !grant_nak && kind_v[tok_ep] == 2'b00) |-> (grant_buf == tok_in));

  // R7: setup start on a control endpoint frees both buffers
  p_setup_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (setup_start && kind_v[setup_ep] == 2'b00) |=> (used_v[$past(setup_ep)] == 2'b00));

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    // R2: after a completion the pointer faces away from the buffer just filled
    p_pingpong_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (done_take_v[i] && kind_v[i] != 2'b00) |=> used_v[i][~act_v[i]]);

    // R9: an interrupt flag rises only after a masked-in completion
    p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ep_irq[i]) |-> $past(done_take_v[i] && mask_v[i]));
  end

endmodule

bind ep_dbuf_mgr ep_dbuf_mgr_chk #(.NUM_EP(NUM_EP)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tok_valid   (tok_valid),
  .tok_in      (tok_in),
  .tok_ep      (tok_ep),
  .grant_buf   (grant_buf),
  .grant_nak   (grant_nak),
  .setup_start (setup_start),
  .setup_ep    (setup_ep),
  .kind_v      (kind_v),
  .act_v       (act_v),
  .used_v      (used_v),
  .done_take_v (done_take_v),
  .mask_v      (mask_v),
  .ep_irq      (ep_irq)
);

// File: tb/ep_dbuf_mgr_tb.sv
`timescale 1ns/1ps
module ep_dbuf_mgr_tb_top;

  localparam int NUM_EP = 4;
  localparam int ADDR_W = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tok_valid = 1'b0;
  logic [1:0]  tok_ep = '0;
  logic        tok_in = 1'b0;
  logic [ADDR_W-1:0] grant_addr;
  logic        grant_buf, grant_nak;
  logic        done_valid = 1'b0;
  logic [1:0]  done_ep = '0;
  logic        done_in = 1'b0;
  logic        setup_start = 1'b0;
  logic [1:0]  setup_ep = '0;
  logic [NUM_EP-1:0] ep_irq;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  ep_dbuf_mgr #(.NUM_EP(NUM_EP), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tok_valid(tok_valid),
    .tok_ep(tok_ep), .tok_in(tok_in), .grant_addr(grant_addr),
    .grant_buf(grant_buf), .grant_nak(grant_nak), .done_valid(done_valid),
    .done_ep(done_ep), .done_in(done_in), .setup_start(setup_start),
    .setup_ep(setup_ep), .ep_irq(ep_irq)
  );

  // bench model of every endpoint
  bit [1:0]  m_kind [NUM_EP];
  bit        m_mask [NUM_EP];
  bit        m_act  [NUM_EP];
  bit        m_irq  [NUM_EP];
  bit        m_used [NUM_EP][2];
  bit [30:0] m_desc [NUM_EP][2];

  function automatic bit m_nak(int e, bit tin);
    bit both = m_used[e][0] & m_used[e][1];
    if (m_kind[e] == 2'd0) return m_used[e][tin];
    if (m_kind[e] == 2'd1) return (tin == 1'b0) | both;
    if (m_kind[e] == 2'd2) return (tin == 1'b1) | both;
    return 1'b1;
  endfunction

  function automatic bit m_sel(int e, bit tin);
    if (m_kind[e] == 2'd0) return tin;
    if (!m_used[e][m_act[e]]) return m_act[e];
    return !m_act[e];
  endfunction

  function automatic logic [31:0] m_reg(int a);
    int e = a / 4;
    case (a % 4)
      0:       return {27'b0, m_act[e], 1'b0, m_mask[e], m_kind[e]};
      1:       return {31'b0, m_irq[e]};
      2:       return {m_used[e][0], m_desc[e][0]};
      default: return {m_used[e][1], m_desc[e][1]};
    endcase
  endfunction

  function automatic logic [NUM_EP-1:0] m_irqv();
    logic [NUM_EP-1:0] v;
    for (int e = 0; e < NUM_EP; e++) v[e] = m_irq[e];
    return v;
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  // every task starts and ends 1 ns after a rising edge
  task automatic wr(int a, logic [31:0] d);
    int e = a / 4;
    reg_addr = 4'(a); reg_wdata = d; reg_we = 1'b1;
    @(posedge clk);
    case (a % 4)
      0: begin m_kind[e] = d[1:0]; m_mask[e] = d[2]; if (d[31]) m_act[e] = 1'b0; end
      1: if (d[0]) m_irq[e] = 1'b0;
      default: begin m_desc[e][a%4-2] = d[30:0]; m_used[e][a%4-2] = 1'b0; end
    endcase
    #1 reg_we = 1'b0;
  endtask

  task automatic rd(int a, string req);
    reg_addr = 4'(a);
    #1 chk(req, reg_rdata, m_reg(a));
    @(posedge clk); #1;
  endtask

  task automatic tok(int e, bit tin, string req);
    bit en, sel;
    tok_valid = 1'b1; tok_ep = 2'(e); tok_in = tin;
    en  = m_nak(e, tin);
    sel = m_sel(e, tin);
    #1 chk(req, {31'b0, grant_nak}, {31'b0, en});
    if (!en) begin
      chk(req, {31'b0, grant_buf}, {31'b0, sel});
      chk(req, {20'b0, grant_addr}, {20'b0, m_desc[e][sel][ADDR_W-1:0]});
    end
    tok_valid = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic done(int e, bit tin);
    bit sel;
    done_valid = 1'b1; done_ep = 2'(e); done_in = tin;
    @(posedge clk);
    if (!m_nak(e, tin)) begin
      sel = m_sel(e, tin);
      m_used[e][sel] = 1'b1;
      if (m_kind[e] != 2'd0) m_act[e] = !sel;
      if (m_mask[e]) m_irq[e] = 1'b1;
    end
    #1 done_valid = 1'b0;
    chk("R9 ep_irq", {28'b0, ep_irq}, {28'b0, m_irqv()});
  endtask

  task automatic setup(int e);
    setup_start = 1'b1; setup_ep = 2'(e);
    @(posedge clk);
    if (m_kind[e] == 2'd0) begin m_used[e][0] = 1'b0; m_used[e][1] = 1'b0; end
    #1 setup_start = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int e = 0; e < NUM_EP; e++) begin
      m_kind[e] = 0; m_mask[e] = 0; m_act[e] = 0; m_irq[e] = 0;
      for (int b = 0; b < 2; b++) begin m_used[e][b] = 0; m_desc[e][b] = 0; end
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state of every register
    for (int a = 0; a < 4 * NUM_EP; a++) rd(a, "R1 reset reg");
    chk("R1 reset irq", {28'b0, ep_irq}, 32'h0);

    // ep1 as IN endpoint: alternation, used flags, full refusal (R2 R3 R4 R8 R10)
    wr(4, 32'h0000_0005);
    wr(6, 32'h0000_0100);
    wr(7, 32'h0000_0200);
    rd(4, "R10 cfg word");
    tok(1, 1'b1, "R2 first grant buf0");
    done(1, 1'b1);
    rd(6, "R3 used bit buf0");
    rd(4, "R2 pointer moved");
    tok(1, 1'b1, "R2 second grant buf1");
    done(1, 1'b1);
    rd(7, "R3 used bit buf1");
    tok(1, 1'b1, "R4 both used nak");
    wr(5, 32'h1);
    rd(5, "R12 irq cleared");
    done(1, 1'b1);
    rd(5, "R4 done ignored when full");
    wr(6, 32'h7abc_0345);
    rd(6, "R8 descriptor loaded used cleared");
    tok(1, 1'b1, "R4 freed buffer granted");
    tok(1, 1'b0, "R5 OUT token on IN endpoint");
    done(1, 1'b0);
    rd(7, "R5 mismatched done ignored");

    // reserved type
    wr(12, 32'h3);
    tok(3, 1'b1, "R5 reserved type nak");
    tok(3, 1'b0, "R5 reserved type nak out");

    // control endpoint (R6 R7)
    wr(0, 32'h4);
    wr(2, 32'h40);
    wr(3, 32'h80);
    tok(0, 1'b0, "R6 ctrl OUT buf0");
    tok(0, 1'b1, "R6 ctrl IN buf1");
    done(0, 1'b0);
    tok(0, 1'b0, "R6 ctrl OUT busy nak");
    tok(0, 1'b1, "R6 ctrl IN still free");
    rd(2, "R6 ctrl buf0 used");
    setup(0);
    rd(2, "R7 setup cleared buf0");
    tok(0, 1'b0, "R7 ctrl OUT after setup");
    setup(1);
    rd(7, "R7 setup on IN endpoint no effect");

    // restart and mask (R11 R9)
    wr(8, 32'h2);
    wr(10, 32'h11);
    wr(11, 32'h22);
    done(2, 1'b0);
    rd(8, "R10 pointer bit reads 1");
    rd(9, "R9 masked off no flag");
    wr(10, 32'h33);
    wr(8, 32'h8000_0006);
    rd(8, "R11 pointer restarted");
    tok(2, 1'b0, "R11 grant buf0 after restart");

    // simultaneous set and clear of the flag (R12)
    reg_addr = 4'd9; reg_wdata = 32'h1; reg_we = 1'b1;
    done_valid = 1'b1; done_ep = 2'd2; done_in = 1'b0;
    @(posedge clk);
    m_used[2][0] = 1'b1; m_act[2] = 1'b1; m_irq[2] = 1'b1;
    #1 reg_we = 1'b0; done_valid = 1'b0;
    rd(9, "R12 set wins over clear");

    // constrained random mix
    for (int n = 0; n < 3000; n++) begin
      int r = $urandom_range(0, 9);
      int e = $urandom_range(0, NUM_EP - 1);
      bit tin = 1'($urandom_range(0, 1));
      case (r)
        0, 1: wr(e * 4 + 2 + $urandom_range(0, 1), $urandom);
        2: wr(e * 4, {($urandom_range(0, 7) == 0), 28'b0, 1'($urandom_range(0, 1)),
                      2'($urandom_range(0, 3))});
        3: wr(e * 4 + 1, {31'b0, 1'($urandom_range(0, 1))});
        4, 9: tok(e, tin, "R2 R4 R5 R6 random token");
        5, 6: done(e, tin);
        7: setup(e);
        default: rd($urandom_range(0, 4 * NUM_EP - 1), "R10 random readback");
      endcase
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule